// File: doc/BRIEF.md
# Dual-Edge Sampling Register with Two-Vector Test Modes

This block is a data register that captures its input on both the rising and the falling transition of a slow enable signal. That gives two samples per enable period. A fast system clock drives the block, and the enable `e_i` is sampled as data. Each storage element is a level-sensitive latch, emulated with one register per bit that is rewritten on every system-clock cycle. Every piece of logic is a controlled-swap primitive, which conserves the number of ones between its inputs and its outputs.

Two latches sit in parallel:
- One latch is transparent while the enable is high.
- The other latch is transparent while the enable is low.
- A splitting gate copies the data input to both latches, so that no net fans out.
- A final controlled swap forwards the output of whichever latch is currently holding. That value is registered onto `q_o`.

Each latch ends in a second swap gate. This gate is steered by a two-bit control and does two jobs. In run mode it returns the stored value as the latch's feedback. In the two test modes it forces the feedback to a constant 0 or a constant 1. Cutting the loops this way lets an all-zeros vector and an all-ones vector expose unidirectional stuck-at faults.

Top module: `det_dual_edge_ff`

## Requirements
- R1: A synchronous active-high `rst_i` clears `q_o`, `pos_store_o` and `neg_store_o` to zero at the next system-clock edge.
- R2: With `pos_mode_i` = 2'b10 (run), on a clock edge where `e_i` is 1 the high-side store takes `d_i`. On a clock edge where `e_i` is 0 it keeps its value.
- R3: With `neg_mode_i` = 2'b10 (run), on a clock edge where `e_i` is 0 the low-side store takes `d_i`. On a clock edge where `e_i` is 1 it keeps its value.
- R4: In run mode on both sides, consider a clock edge at which `e_i` differs from its value at the previous edge, that previous edge not being in reset. At such an edge, `q_o` loads the `d_i` present at the previous edge. This applies to enable transitions in both directions.
- R5: In run mode, `q_o` does not change at a clock edge where `e_i` equals its value at the previous edge.
- R6: Each loop output is driven as follows:
  - it equals its store when that side's mode is 2'b10;
  - it is all zeros when the mode is 2'b00;
  - it is all ones when the mode is 2'b11.
- R7: All-zeros test: with both modes 2'b00, `d_i` = 0 and `e_i` = 0, both stores are zero after one clock edge and `q_o` is zero after two, whatever was stored before.
- R8: All-ones test: with both modes 2'b11, `d_i` all ones and `e_i` = 1, both stores are all ones after one clock edge and `q_o` is all ones after two, whatever was stored before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| d_i | input | WIDTH | Data to sample |
| e_i | input | 1 | Enable; both of its transitions capture data |
| pos_mode_i | input | 2 | High-side latch control: bit 0 is the low constant, bit 1 is the high constant |
| neg_mode_i | input | 2 | Low-side latch control, same encoding |
| q_o | output | WIDTH | Registered output taken from the holding latch |
| pos_store_o | output | WIDTH | Stored value of the high-side latch |
| neg_store_o | output | WIDTH | Stored value of the low-side latch |
| pos_loop_o | output | WIDTH | Feedback returned to the high-side latch |
| neg_loop_o | output | WIDTH | Feedback returned to the low-side latch |

## Verification
The bench steps the enable with toggle periods of one to four cycles over random data, then sweeps every data value while toggling the enable on each cycle. The one-cycle period is the hard case. A design that forwarded the transparent latch instead of the holding one would show the current data, one cycle early. A design that sampled only one transition would miss every second value. The test modes are entered with ones already stored. A feedback path that was not cut would keep the old ones and fail the all-zeros check, and a loop output stuck in run mode would be caught the same way. A final reset from a state of all ones checks the clearing.

// File: rtl/det_fredkin_pkg.sv
package det_fredkin_pkg;

  // Loop control encodings: bit 0 is the low constant, bit 1 the high constant.
  localparam logic [1:0] MODE_RUN  = 2'b10;
  localparam logic [1:0] MODE_ZERO = 2'b00;
  localparam logic [1:0] MODE_ONE  = 2'b11;

  // Controlled swap, straight output: a when c is 0, b when c is 1.
  function automatic logic cswap_pass(input logic c, input logic a, input logic b);
    return c ? b : a;
  endfunction

  // Controlled swap, crossed output: b when c is 0, a when c is 1.
  function automatic logic cswap_cross(input logic c, input logic a, input logic b);
    return c ? a : b;
  endfunction

endpackage

// File: rtl/det_d_split.sv
module det_d_split #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] to_pos_o,
  output logic [WIDTH-1:0] to_neg_o
);
  import det_fredkin_pkg::*;

  // One swap gate per bit: the control line passes through as one copy, and
  // constant 0/1 inputs steered by it rebuild a second copy without fanout.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign to_pos_o[b] = d_i[b];
    assign to_neg_o[b] = cswap_pass(d_i[b], 1'b0, 1'b1);
  end
endmodule

// File: rtl/det_half_latch.sv
module det_half_latch #(
  parameter int WIDTH  = 4,
  parameter bit POS_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             e_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic [1:0]       mode_i,
  output logic [WIDTH-1:0] store_o,
  output logic [WIDTH-1:0] loop_o
);
  import det_fredkin_pkg::*;

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    // Capture gate: the enable steers between the data and the feedback.
    if (POS_EN) begin : g_high
      assign state_d[b] = cswap_pass(e_i, loop_o[b], d_i[b]);
    end else begin : g_low
      assign state_d[b] = cswap_pass(e_i, d_i[b], loop_o[b]);
    end
    // Loop gate: the stored bit steers between the two mode constants.
    assign loop_o[b] = cswap_pass(state_q[b], mode_i[0], mode_i[1]);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) state_q <= '0;
    else       state_q <= state_d;
  end

  assign store_o = state_q;
endmodule

// File: rtl/det_dual_edge_ff.sv
module det_dual_edge_ff #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic             e_i,
  input  logic [1:0]       pos_mode_i,
  input  logic [1:0]       neg_mode_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] pos_store_o,
  output logic [WIDTH-1:0] neg_store_o,
  output logic [WIDTH-1:0] pos_loop_o,
  output logic [WIDTH-1:0] neg_loop_o
);
  import det_fredkin_pkg::*;

  logic [WIDTH-1:0] d_pos, d_neg, q_d, q_r;

  det_d_split #(.WIDTH(WIDTH)) u_split (
    .d_i(d_i), .to_pos_o(d_pos), .to_neg_o(d_neg)
  );

  det_half_latch #(.WIDTH(WIDTH), .POS_EN(1'b1)) u_high (
    .clk_i(clk_i), .rst_i(rst_i), .e_i(e_i), .d_i(d_pos),
    .mode_i(pos_mode_i), .store_o(pos_store_o), .loop_o(pos_loop_o)
  );

  det_half_latch #(.WIDTH(WIDTH), .POS_EN(1'b0)) u_low (
    .clk_i(clk_i), .rst_i(rst_i), .e_i(e_i), .d_i(d_neg),
    .mode_i(neg_mode_i), .store_o(neg_store_o), .loop_o(neg_loop_o)
  );

  // Output gate forwards the latch that is holding: the low side while the
  // enable is high, the high side while it is low.
  for (genvar b = 0; b < WIDTH; b++) begin : g_out
    assign q_d[b] = cswap_pass(e_i, pos_store_o[b], neg_store_o[b]);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) q_r <= '0;
    else       q_r <= q_d;
  end

  assign q_o = q_r;
endmodule

// File: rtl/det_dual_edge_ff_chk.sv
module det_dual_edge_ff_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic [WIDTH-1:0] d_i,
  input logic             e_i,
  input logic [1:0]       pos_mode_i,
  input logic [1:0]       neg_mode_i,
  input logic [WIDTH-1:0] q_o,
  input logic [WIDTH-1:0] pos_store_o,
  input logic [WIDTH-1:0] neg_store_o,
  input logic [WIDTH-1:0] pos_loop_o,
  input logic [WIDTH-1:0] neg_loop_o
);
  import det_fredkin_pkg::*;

  logic run_now;
  assign run_now = (pos_mode_i == MODE_RUN) && (neg_mode_i == MODE_RUN);

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    rst_i |=> (q_o == '0) && (pos_store_o == '0) && (neg_store_o == '0));

  assert_high_capture_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (pos_mode_i == MODE_RUN && e_i) |=> pos_store_o == $past(d_i));

  assert_low_capture_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (neg_mode_i == MODE_RUN && !e_i) |=> neg_store_o == $past(d_i));

  assert_edge_capture_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_now && $past(run_now) && !$past(rst_i) && e_i != $past(e_i))
      |=> q_o == $past(d_i, 2));

  assert_no_edge_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_now && $past(run_now) && !$past(rst_i) && e_i == $past(e_i))
      |=> $stable(q_o));

  assert_loop_run_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (pos_mode_i == MODE_RUN) |-> pos_loop_o == pos_store_o);

  assert_loop_zero_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (neg_mode_i == MODE_ZERO) |-> neg_loop_o == '0);

  assert_zero_cut_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (pos_mode_i == MODE_ZERO && !e_i) |=> pos_store_o == '0);

  assert_one_cut_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (neg_mode_i == MODE_ONE && e_i) |=> neg_store_o == {WIDTH{1'b1}});
endmodule

bind det_dual_edge_ff det_dual_edge_ff_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .d_i(d_i), .e_i(e_i),
  .pos_mode_i(pos_mode_i), .neg_mode_i(neg_mode_i), .q_o(q_o),
  .pos_store_o(pos_store_o), .neg_store_o(neg_store_o),
  .pos_loop_o(pos_loop_o), .neg_loop_o(neg_loop_o)
);

// File: tb/sim_det_dual_edge_ff.sv
module sim_det_dual_edge_ff;
  localparam int W = 4;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0, rst;
  logic [W-1:0] d;
  logic e;
  logic [1:0] pm, nm;
  logic [W-1:0] q, ps, ns, pl, nl;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench model of the requirements
  logic [W-1:0] mq, mp, mn, ld;
  logic le;

  always #4 clk = ~clk;

  det_dual_edge_ff #(.WIDTH(W)) u0 (
    .clk_i(clk), .rst_i(rst), .d_i(d), .e_i(e), .pos_mode_i(pm),
    .neg_mode_i(nm), .q_o(q), .pos_store_o(ps), .neg_store_o(ns),
    .pos_loop_o(pl), .neg_loop_o(nl)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Called just after a falling edge; the next rising edge takes nd/ne.
  task automatic drive(input logic [W-1:0] nd, input logic ne);
    bit toggled;
    toggled = (ne != le);
    d = nd; e = ne;
    if (toggled) mq = ld;
    if (ne) mp = nd; else mn = nd;
    le = ne; ld = nd;
    @(negedge clk);
    check(toggled ? "R4 q after enable change" : "R5 q without enable change", q, mq);
    check("R2 high-side store", ps, mp);
    check("R3 low-side store", ns, mn);
    check("R6 run-mode loop", pl, ps);
  endtask

  task automatic do_reset();
    rst = 1'b1; d = '0; e = 1'b0; pm = 2'b10; nm = 2'b10;
    repeat (3) @(negedge clk);
    check("R1 reset q", q, '0);
    check("R1 reset high store", ps, '0);
    check("R1 reset low store", ns, '0);
    rst = 1'b0;
    mq = '0; mp = '0; mn = '0; ld = '0; le = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    drive(W'($urandom), 1'b0);
    // enable toggle periods 1..4 over random data
    for (int p = 1; p <= 4; p++)
      for (int i = 0; i < 40; i++)
        drive(W'($urandom), ((i / p) % 2) == 0);
    // every data value with a toggle on each cycle
    for (int v = 0; v < (1 << W); v++) drive(W'(v), ~le);
    for (int v = 0; v < (1 << W); v++) drive(W'(v), (v % 3) == 0);

    // load ones into both latches, then all-zeros test
    drive(ONES, 1'b1);
    drive(ONES, 1'b0);
    pm = 2'b00; nm = 2'b00; d = '0; e = 1'b0;
    #1;
    check("R6 zero-mode high loop", pl, '0);
    check("R6 zero-mode low loop", nl, '0);
    @(negedge clk);
    check("R7 high store cleared", ps, '0);
    check("R7 low store cleared", ns, '0);
    @(negedge clk);
    check("R7 q cleared", q, '0);

    // all-ones test from the cleared state
    pm = 2'b11; nm = 2'b11; d = ONES; e = 1'b1;
    #1;
    check("R6 one-mode high loop", pl, ONES);
    check("R6 one-mode low loop", nl, ONES);
    @(negedge clk);
    check("R8 high store set", ps, ONES);
    check("R8 low store set", ns, ONES);
    @(negedge clk);
    check("R8 q set", q, ONES);

    do_reset();
    drive(4'h5, 1'b0);
    drive(4'hA, 1'b1);
    drive(4'h3, 1'b1);
    drive(4'hC, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule